// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block is the timing engine of a display output port. It runs on the pixel clock and walks a raster: a pixel position within the line and an absolute pixel-clock offset within the frame. From that position, and a set of programmed limits, it produces horizontal and vertical sync, data enable, three nested windows (display, active and data-valid), and the pixel value sent to the panel. Outside the active area inside the display window it sends a border colour. Inside the active area it passes upstream pixels, and when upstream has no valid pixel it sends an underflow colour.

Vertical limits are not line numbers. Each one is an offset counted in pixel clocks from the start of the frame, so a fixed hsync skew can be added to it. The data-valid window begins with the display window and lasts for a programmed number of clocks. In double-pixel bus mode that count is halved. A 16-bit frame counter and a 16-bit line counter are brought out. Software can clear the line counter.

Configuration goes through a simple word-write port. Writes land in a shadow copy. The engine takes the shadow copy at once while stopped, and only at a frame boundary while running, so a frame is never drawn with mixed settings.

Top module: `raster_timing_gen`

## Requirements
- R1: Register 0 bit 0 runs (1) or stops (0) the engine. One clock after the engine stops, and from then on: the display, active and data-valid windows are 0, the pixel output is 0, hsync/vsync/data enable sit at their non-asserted level (equal to the matching polarity bit), and both counters read 0.
- R2: Register 2 holds the line period in clocks in bits [31:16] and the hsync width in bits [15:0]. Hsync is asserted for the first hsync-width clocks of each line.
- R3: Register 3 holds the frame period in pixel clocks and register 4 the vsync width in pixel clocks. Vsync is asserted while the frame offset is below the vsync width. The frame offset wraps to 0 after frame-period clocks.
- R4: The display window is set where the frame offset lies within registers 5 (first) and 6 (last) inclusive, and the pixel position lies within register 9 inclusive: last in bits [31:16], first in bits [15:0].
- R5: Register 1 bit 29 limits the active window horizontally to register 10 (same packing as register 9). Bit 30 limits it vertically to registers 7 and 8 (first and last frame offset). A dimension that is not enabled follows the display window. The active window never leaves the display window, and data enable equals the active window.
- R6: Register 13 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable.
- R7: The data-valid window is the part of the display window whose pixel position is below display-first plus the width in register 15 bits [15:0]. When register 14 bit 0 is set, that width is halved (rounded down).
- R8: The pixel output is the upstream pixel when active and the upstream valid is set. It is the underflow colour (register 12) when active and valid is clear, the border colour (register 11) when in the display window but not active, and 0 elsewhere.
- R9: The frame counter advances by one at each frame wrap. The line counter counts lines completed in the current frame and returns to 0 at the frame wrap.
- R10: A write to register 16 with bit 31 set clears the line counter on that clock, and counting then resumes.
- R11: While running, writes to registers 1–15 take effect on the first clock of the next frame. While stopped they take effect within two clocks.
- R12: Syncs, enable, windows and pixel are registered and show the raster position of the previous clock. The first clock after the run bit is written shows frame offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 5 | register index |
| reg_wdata | input | 32 | register write data |
| up_valid | input | 1 | upstream pixel is present |
| up_data | input | CW | upstream pixel value |
| hsync_o | output | 1 | horizontal sync after polarity |
| vsync_o | output | 1 | vertical sync after polarity |
| den_o | output | 1 | data enable after polarity |
| disp_win_o | output | 1 | display window |
| act_win_o | output | 1 | active window |
| data_win_o | output | 1 | data-valid window |
| pix_o | output | CW | pixel sent to the panel |
| frame_cnt_o | output | 16 | frame counter |
| line_cnt_o | output | 16 | line counter |

## Verification
The hardest situation to reach is a register write landing in the middle of a running frame. Its effect has to stay invisible until the exact clock where the frame offset wraps. The stimulus gets there by enabling the engine, counting clocks from the enable write, and issuing a border-colour write at a known mid-frame clock. Pixels are then compared against the old colour through the end of frame zero and against the new colour from the wrap onward. The same clock counting places a line-counter clear partway through a line, so the counter restarts from an offset that is not aligned to a line.

// File: rtl/raster_timing_pkg.sv
`timescale 1ns/1ps
package raster_timing_pkg;

    localparam int REG_AW = 5;
    localparam int HW     = 16;
    localparam int OW     = 32;

    typedef enum logic [REG_AW-1:0] {
        RA_RUN    = 5'd0,
        RA_CFG    = 5'd1,
        RA_LINE   = 5'd2,
        RA_FPER   = 5'd3,
        RA_VPW    = 5'd4,
        RA_DVS    = 5'd5,
        RA_DVE    = 5'd6,
        RA_AVS    = 5'd7,
        RA_AVE    = 5'd8,
        RA_DH     = 5'd9,
        RA_AH     = 5'd10,
        RA_BORDER = 5'd11,
        RA_UFLOW  = 5'd12,
        RA_POL    = 5'd13,
        RA_CFG2   = 5'd14,
        RA_DWID   = 5'd15,
        RA_LCLR   = 5'd16
    } reg_addr_e;

    typedef struct packed {
        logic          act_h_en;
        logic          act_v_en;
        logic [HW-1:0] hper;
        logic [HW-1:0] hsw;
        logic [OW-1:0] fper;
        logic [OW-1:0] vpw;
        logic [OW-1:0] dvs;
        logic [OW-1:0] dve;
        logic [OW-1:0] avs;
        logic [OW-1:0] ave;
        logic [HW-1:0] dhs;
        logic [HW-1:0] dhe;
        logic [HW-1:0] ahs;
        logic [HW-1:0] ahe;
        logic [2:0]    pol;
        logic          dbl;
        logic [HW-1:0] dwid;
    } timing_t;

endpackage

// File: rtl/raster_timing_regs.sv
`timescale 1ns/1ps
module raster_timing_regs
    import raster_timing_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              frame_end,
    output logic              run_o,
    output logic              line_clr_o,
    output timing_t           cfg_o,
    output logic [CW-1:0]     border_o,
    output logic [CW-1:0]     uflow_o
);

    typedef struct packed {
        logic          run;
        timing_t       shd;
        timing_t       act;
        logic [CW-1:0] b_shd;
        logic [CW-1:0] b_act;
        logic [CW-1:0] u_shd;
        logic [CW-1:0] u_act;
    } rf_t;

    rf_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        line_clr_o = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                RA_RUN:    st_d.run = wr_data[0];
                RA_CFG: begin
                    st_d.shd.act_h_en = wr_data[29];
                    st_d.shd.act_v_en = wr_data[30];
                end
                RA_LINE: begin
                    st_d.shd.hper = wr_data[31:16];
                    st_d.shd.hsw  = wr_data[15:0];
                end
                RA_FPER:   st_d.shd.fper = wr_data;
                RA_VPW:    st_d.shd.vpw  = wr_data;
                RA_DVS:    st_d.shd.dvs  = wr_data;
                RA_DVE:    st_d.shd.dve  = wr_data;
                RA_AVS:    st_d.shd.avs  = wr_data;
                RA_AVE:    st_d.shd.ave  = wr_data;
                RA_DH: begin
                    st_d.shd.dhe = wr_data[31:16];
                    st_d.shd.dhs = wr_data[15:0];
                end
                RA_AH: begin
                    st_d.shd.ahe = wr_data[31:16];
                    st_d.shd.ahs = wr_data[15:0];
                end
                RA_BORDER: st_d.b_shd    = wr_data[CW-1:0];
                RA_UFLOW:  st_d.u_shd    = wr_data[CW-1:0];
                RA_POL:    st_d.shd.pol  = wr_data[2:0];
                RA_CFG2:   st_d.shd.dbl  = wr_data[0];
                RA_DWID:   st_d.shd.dwid = wr_data[15:0];
                RA_LCLR:   line_clr_o    = wr_data[31];
                default: ;
            endcase
        end
        // shadow set becomes live while stopped or at a frame wrap
        if (!st_q.run || frame_end) begin
            st_d.act   = st_q.shd;
            st_d.b_act = st_q.b_shd;
            st_d.u_act = st_q.u_shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o    = st_q.run;
    assign cfg_o    = st_q.act;
    assign border_o = st_q.b_act;
    assign uflow_o  = st_q.u_act;

endmodule

// File: rtl/raster_timing_counter.sv
`timescale 1ns/1ps
module raster_timing_counter
    import raster_timing_pkg::*;
#(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            line_clr,
    input  logic [HW-1:0]   hper,
    input  logic [OW-1:0]   fper,
    output logic [OW-1:0]   pos_o,
    output logic [HW-1:0]   hcnt_o,
    output logic [CNTW-1:0] line_o,
    output logic [CNTW-1:0] frame_o,
    output logic            frame_end_o
);

    typedef struct packed {
        logic [OW-1:0]   pos;
        logic [HW-1:0]   hcnt;
        logic [CNTW-1:0] line;
        logic [CNTW-1:0] frame;
    } rc_t;

    rc_t st_q, st_d;

    assign frame_end_o = run && (st_q.pos == fper - 1'b1);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (frame_end_o) begin
            st_d.pos   = '0;
            st_d.hcnt  = '0;
            st_d.line  = '0;
            st_d.frame = st_q.frame + 1'b1;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
            if (st_q.hcnt == hper - 1'b1) begin
                st_d.hcnt = '0;
                st_d.line = st_q.line + 1'b1;
            end else begin
                st_d.hcnt = st_q.hcnt + 1'b1;
            end
            if (line_clr) st_d.line = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o   = st_q.pos;
    assign hcnt_o  = st_q.hcnt;
    assign line_o  = st_q.line;
    assign frame_o = st_q.frame;

endmodule

// File: rtl/raster_timing_pixout.sv
`timescale 1ns/1ps
module raster_timing_pixout
    import raster_timing_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  timing_t       cfg,
    input  logic [CW-1:0] border,
    input  logic [CW-1:0] uflow,
    input  logic [OW-1:0] pos,
    input  logic [HW-1:0] hcnt,
    input  logic          up_valid,
    input  logic [CW-1:0] up_data,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          den_o,
    output logic          disp_o,
    output logic          act_o,
    output logic          data_o,
    output logic [CW-1:0] pix_o
);

    typedef struct packed {
        logic          hs;
        logic          vs;
        logic          de;
        logic          disp;
        logic          act;
        logic          data;
        logic [CW-1:0] pix;
    } po_t;

    po_t st_q, st_d;

    logic          v_disp, h_disp, in_disp, h_act, v_act, in_act, in_data;
    logic [HW:0]   data_end;
    logic [HW-1:0] dw_eff;

    always_comb begin
        v_disp   = (pos >= cfg.dvs) && (pos <= cfg.dve);
        h_disp   = (hcnt >= cfg.dhs) && (hcnt <= cfg.dhe);
        in_disp  = v_disp && h_disp;
        h_act    = !cfg.act_h_en || ((hcnt >= cfg.ahs) && (hcnt <= cfg.ahe));
        v_act    = !cfg.act_v_en || ((pos >= cfg.avs) && (pos <= cfg.ave));
        in_act   = in_disp && h_act && v_act;
        dw_eff   = cfg.dbl ? (cfg.dwid >> 1) : cfg.dwid;
        data_end = {1'b0, cfg.dhs} + {1'b0, dw_eff};
        in_data  = in_disp && ({1'b0, hcnt} < data_end);

        st_d.hs   = cfg.pol[0];
        st_d.vs   = cfg.pol[1];
        st_d.de   = cfg.pol[2];
        st_d.disp = 1'b0;
        st_d.act  = 1'b0;
        st_d.data = 1'b0;
        st_d.pix  = '0;
        if (run) begin
            st_d.hs   = ({16'd0, hcnt} < {16'd0, cfg.hsw}) ^ cfg.pol[0];
            st_d.vs   = (pos < cfg.vpw) ^ cfg.pol[1];
            st_d.de   = in_act ^ cfg.pol[2];
            st_d.disp = in_disp;
            st_d.act  = in_act;
            st_d.data = in_data;
            if (in_act)       st_d.pix = up_valid ? up_data : uflow;
            else if (in_disp) st_d.pix = border;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hsync_o = st_q.hs;
    assign vsync_o = st_q.vs;
    assign den_o   = st_q.de;
    assign disp_o  = st_q.disp;
    assign act_o   = st_q.act;
    assign data_o  = st_q.data;
    assign pix_o   = st_q.pix;

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
    import raster_timing_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [4:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          up_valid,
    input  logic [CW-1:0] up_data,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          den_o,
    output logic          disp_win_o,
    output logic          act_win_o,
    output logic          data_win_o,
    output logic [CW-1:0] pix_o,
    output logic [15:0]   frame_cnt_o,
    output logic [15:0]   line_cnt_o
);

    localparam int CNTW = 16;

    logic          run;
    logic          line_clr;
    logic          frame_end;
    timing_t       cfg;
    logic [CW-1:0] border, uflow;
    logic [OW-1:0] pos;
    logic [HW-1:0] hcnt;

    raster_timing_regs #(.CW(CW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .frame_end  (frame_end),
        .run_o      (run),
        .line_clr_o (line_clr),
        .cfg_o      (cfg),
        .border_o   (border),
        .uflow_o    (uflow)
    );

    raster_timing_counter #(.CNTW(CNTW)) cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .line_clr    (line_clr),
        .hper        (cfg.hper),
        .fper        (cfg.fper),
        .pos_o       (pos),
        .hcnt_o      (hcnt),
        .line_o      (line_cnt_o),
        .frame_o     (frame_cnt_o),
        .frame_end_o (frame_end)
    );

    raster_timing_pixout #(.CW(CW)) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cfg      (cfg),
        .border   (border),
        .uflow    (uflow),
        .pos      (pos),
        .hcnt     (hcnt),
        .up_valid (up_valid),
        .up_data  (up_data),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .den_o    (den_o),
        .disp_o   (disp_win_o),
        .act_o    (act_win_o),
        .data_o   (data_win_o),
        .pix_o    (pix_o)
    );

endmodule

// File: rtl/raster_timing_gen_chk.sv
`timescale 1ns/1ps
module raster_timing_gen_chk #(
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          line_clr,
    input logic          disp_win,
    input logic          act_win,
    input logic          data_win,
    input logic [CW-1:0] pix,
    input logic [15:0]   frame_cnt,
    input logic [15:0]   line_cnt
);

    // stopped engine: windows and pixel quiet on the following clock
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!disp_win && !act_win && !data_win && pix == '0));

    assert_act_in_disp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_win |-> disp_win);

    assert_data_in_disp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_win |-> disp_win);

    assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$stable(frame_cnt)) |-> (frame_cnt == $past(frame_cnt) + 16'd1));

    assert_line_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_clr |=> (line_cnt == 16'd0));

endmodule

bind raster_timing_gen raster_timing_gen_chk #(.CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .line_clr  (line_clr),
    .disp_win  (disp_win_o),
    .act_win   (act_win_o),
    .data_win  (data_win_o),
    .pix       (pix_o),
    .frame_cnt (frame_cnt_o),
    .line_cnt  (line_cnt_o)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;

    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          up_valid = 1'b0;
    logic [CW-1:0] up_data = '0;
    logic          hsync_o, vsync_o, den_o, disp_win_o, act_win_o, data_win_o;
    logic [CW-1:0] pix_o;
    logic [15:0]   frame_cnt_o, line_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side model of the programmed geometry
    int m_hper, m_fper, m_hsw, m_vpw, m_dvs, m_dve, m_dhs, m_dhe;
    int m_ahs, m_ahe, m_avs, m_ave, m_hen, m_ven, m_pol, m_dend;
    int m_b0, m_b1, m_uf;
    int m_wr_k, m_wr_addr, m_wr_data, m_clr_k;

    always #2.5 clk = ~clk;

    raster_timing_gen #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .up_valid(up_valid), .up_data(up_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .den_o(den_o),
        .disp_win_o(disp_win_o), .act_win_o(act_win_o), .data_win_o(data_win_o),
        .pix_o(pix_o), .frame_cnt_o(frame_cnt_o), .line_cnt_o(line_cnt_o)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        reg_we    = 1'b1;
        reg_addr  = addr[4:0];
        reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic setup(int hsw, int hbp, int w, int hfp, int vsw, int vbp, int ht, int vfp,
                         int skew, int xres, int yres, int hen, int ven, int pol,
                         int dbl, int dwid, int border, int uf);
        int lines;
        m_hper = hsw + hbp + w + hfp;
        lines  = vsw + vbp + ht + vfp;
        m_fper = lines * m_hper;
        m_hsw  = hsw;
        m_vpw  = vsw * m_hper;
        m_dvs  = (vsw + vbp) * m_hper + skew;
        m_dve  = (lines - vfp) * m_hper + skew - 1;
        m_dhs  = hsw + hbp;
        m_dhe  = m_hper - hfp - 1;
        m_ahs  = m_dhs;
        m_ahe  = m_ahs + xres - 1;
        m_avs  = m_dvs;
        m_ave  = m_avs + yres * m_hper - 1;
        m_hen  = hen;
        m_ven  = ven;
        m_pol  = pol;
        m_dend = m_dhs + (dbl != 0 ? dwid / 2 : dwid);
        m_b0   = border;
        m_b1   = border;
        m_uf   = uf;
        m_wr_k = -1;
        m_clr_k = -1;
        wr(2, (m_hper << 16) | hsw);
        wr(3, m_fper);
        wr(4, m_vpw);
        wr(5, m_dvs);
        wr(6, m_dve);
        wr(7, m_avs);
        wr(8, m_ave);
        wr(9, (m_dhe << 16) | m_dhs);
        wr(10, (m_ahe << 16) | m_ahs);
        wr(1, (ven << 30) | (hen << 29));
        wr(11, border);
        wr(12, uf);
        wr(13, pol);
        wr(14, dbl);
        wr(15, dwid);
    endtask

    // enable, then check every output for n clocks against the model
    task automatic run_and_check(int n);
        wr(0, 1);
        for (int k = 1; k <= n; k++) begin
            int p, hc, fp, fr, eline, bcol;
            bit dv, dh, disp, ah, av, act, dat, vld;
            logic [CW-1:0] dval;
            p = k - 1;
            vld  = (p % 5) != 0;
            dval = CW'(p * 7 + 3);
            up_valid = vld;
            up_data  = dval;
            if (k == m_wr_k || k == m_clr_k) begin
                reg_we = 1'b1; reg_addr = m_wr_addr[4:0]; reg_wdata = m_wr_data;
            end
            @(posedge clk);
            @(negedge clk);
            reg_we = 1'b0;
            hc = p % m_hper;
            fp = p % m_fper;
            fr = p / m_fper;
            dv = fp >= m_dvs && fp <= m_dve;
            dh = hc >= m_dhs && hc <= m_dhe;
            disp = dv && dh;
            ah = (m_hen == 0) || (hc >= m_ahs && hc <= m_ahe);
            av = (m_ven == 0) || (fp >= m_avs && fp <= m_ave);
            act = disp && ah && av;
            dat = disp && hc < m_dend;
            bcol = (fr >= 1) ? m_b1 : m_b0;
            chk((k == 1) ? "R12" : "R2", "hsync", hsync_o, (hc < m_hsw) ^ m_pol[0]);
            chk((k == 1) ? "R12" : "R3", "vsync", vsync_o, (fp < m_vpw) ^ m_pol[1]);
            chk("R4", "disp_win", disp_win_o, disp);
            chk("R5", "act_win", act_win_o, act);
            chk("R6", "den", den_o, act ^ m_pol[2]);
            chk("R7", "data_win", data_win_o, dat);
            chk((m_wr_k > 0) ? "R11" : "R8", "pix", pix_o,
                act ? (vld ? dval : m_uf) : (disp ? bcol : 0));
            chk("R9", "frame_cnt", frame_cnt_o, k / m_fper);
            if (m_clr_k > 0 && k >= m_clr_k && k < m_fper)
                eline = k / m_hper - m_clr_k / m_hper;
            else
                eline = (k % m_fper) / m_hper;
            chk((m_clr_k > 0) ? "R10" : "R9", "line_cnt", line_cnt_o, eline);
        end
    endtask

    task automatic check_stopped(string why);
        wr(0, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R1", {why, " hsync"}, hsync_o, m_pol[0]);
        chk("R1", {why, " vsync"}, vsync_o, m_pol[1]);
        chk("R1", {why, " den"}, den_o, m_pol[2]);
        chk("R1", {why, " windows"}, {disp_win_o, act_win_o, data_win_o}, 0);
        chk("R1", {why, " pix"}, pix_o, 0);
        chk("R1", {why, " counters"}, {frame_cnt_o, line_cnt_o}, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "reset syncs", {hsync_o, vsync_o, den_o}, 0);
        chk("R1", "reset windows", {disp_win_o, act_win_o, data_win_o}, 0);
        chk("R1", "reset pix", pix_o, 0);
        chk("R1", "reset counters", {frame_cnt_o, line_cnt_o}, 0);
    endtask

    task automatic t_basic;
        setup(2, 3, 8, 2, 1, 1, 4, 1, 0, 6, 3, 1, 1, 0, 0, 8, 24'h00AA55, 24'hFF0000);
        run_and_check(2 * m_fper + 5);
        check_stopped("basic");
    endtask

    task automatic t_skew_pol_double;
        setup(3, 2, 10, 3, 2, 1, 3, 2, 4, 0, 0, 0, 0, 7, 1, 9, 24'h123456, 24'h0F0F0F);
        run_and_check(m_fper + 20);
        check_stopped("skew");
    endtask

    task automatic t_midframe_write;
        setup(2, 3, 8, 2, 1, 1, 4, 1, 0, 6, 3, 1, 0, 0, 0, 8, 24'h000111, 24'h222000);
        m_wr_k = 20; m_wr_addr = 11; m_wr_data = 24'h333333;
        m_b1 = 24'h333333;
        run_and_check(2 * m_fper);
        check_stopped("midframe");
    endtask

    task automatic t_line_clear;
        setup(2, 3, 8, 2, 1, 1, 4, 1, 0, 6, 3, 1, 1, 0, 0, 8, 24'h0000AA, 24'h00BB00);
        m_clr_k = 40; m_wr_addr = 16; m_wr_data = 32'h8000_0000;
        run_and_check(m_fper + 10);
        check_stopped("lineclr");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_pol = 0;
        t_reset();
        t_basic();
        t_skew_pol_double();
        t_midframe_write();
        t_line_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule